// File: doc/BRIEF.md
# Configurable Trigger Interrupt Controller

This block gathers a word of asynchronous interrupt lines and turns them into two request outputs and a wake output. Each line has its own three-bit trigger code. The code selects rising-edge, falling-edge or dual-edge capture, high-level or low-level sensing, or turns the line off. Edge events are held in two capture words, one for each direction, until software clears them by writing ones. Level sources follow the synchronized input directly.

A per-source mask gates what becomes pending. A per-source steering bit then sends each pending source either to the high-priority request or to the low-priority request. Software reads one pending word for each request. It programs every control word through a pair of addresses: one sets the bits written as one and the other clears them. A separate wake-enable word decides which active sources may raise the wake output. The mask does not gate the wake output.

Top module: `trig_irq_ctrl`

## Requirements
- R1: After reset, the three trigger-code words, the steering word, the wake-enable word, the mask word, both capture words and the test word read zero. The source word reads all ones. All three outputs are low.
- R2: Control words sit in pairs: trigger bit 0 at 0x40/0x44, trigger bit 1 at 0x48/0x4C, trigger bit 2 at 0x50/0x54, source at 0x58/0x5C, steering at 0x60/0x64, wake-enable at 0x68/0x6C, mask at 0x70/0x74. Reading the lower address returns the word. Writing it sets each bit written as one. Writing the upper address clears each bit written as one. Bits written as zero are unchanged.
- R3: Each input passes through two flip-flops before use. A level change applied before clock edge n reaches the request outputs after edge n+1.
- R4: Trigger code (bit2 bit1 bit0) 001 captures rising edges into the rise word (read 0x78). Code 010 captures falling edges into the fall word (read 0x7C). Code 011 captures both.
- R5: Code 101 makes the source active while its synchronized input is high. Code 110 makes it active while the input is low. Nothing is captured in either level mode.
- R6: Codes 000, 100 and 111 never capture an edge and are never pending.
- R7: Writing ones to 0x78 or 0x7C clears those capture bits. An edge detected in the same cycle as its clear stays captured.
- R8: A source is pending only while its mask bit is one.
- R9: A pending source with its steering bit set appears in the word read at 0x54 and drives req_hi. A pending source with the bit clear appears at 0x5C and drives req_lo. Each request is high whenever its pending word is nonzero.
- R10: wake_o is high while any active source has its wake-enable bit set, whatever its mask bit.
- R11: The test word at 0x80 stores and returns a full data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq_in | input | NSRC | Asynchronous interrupt lines |
| req_hi | output | 1 | High-priority request |
| req_lo | output | 1 | Low-priority request |
| wake_o | output | 1 | Wake indication |

## Verification
The hardest case to reach from the ports is a capture clear that lands in the very cycle an edge is detected. The bench produces it by raising a line and then waiting exactly two clock edges for the synchronizer. It then issues the clear write so that it meets the capture on the third edge, and reads the bit back. The three-cycle input path also makes the exact cycle of each request change easy to get wrong. A behavioural model that keeps a history queue of the inputs predicts the outputs and the read data on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned ADDR_W    = 8;
   localparam int unsigned NUM_BANKS = 7;
   localparam logic [7:0]  BANK_BASE = 8'h40;
   localparam int unsigned BANK_STEP = 8;
   localparam int unsigned CLR_OFS   = 4;

   localparam int unsigned BK_TRG0 = 0;
   localparam int unsigned BK_TRG1 = 1;
   localparam int unsigned BK_TRG2 = 2;
   localparam int unsigned BK_SRC  = 3;
   localparam int unsigned BK_STEER = 4;
   localparam int unsigned BK_WAKE = 5;
   localparam int unsigned BK_MASK = 6;

   localparam logic [7:0] OFS_PEND_HI = 8'h54;
   localparam logic [7:0] OFS_PEND_LO = 8'h5C;
   localparam logic [7:0] OFS_RISE    = 8'h78;
   localparam logic [7:0] OFS_FALL    = 8'h7C;
   localparam logic [7:0] OFS_TEST    = 8'h80;

   typedef enum logic [2:0] {
      TRIG_OFF  = 3'b000,
      TRIG_RISE = 3'b001,
      TRIG_FALL = 3'b010,
      TRIG_BOTH = 3'b011,
      TRIG_HIGH = 3'b101,
      TRIG_LOW  = 3'b110
   } trig_e;

   function automatic logic [7:0] bank_set_addr(input int unsigned k);
      return BANK_BASE + 8'(BANK_STEP * k);
   endfunction

   function automatic logic [7:0] bank_clr_addr(input int unsigned k);
      return BANK_BASE + 8'(BANK_STEP * k + CLR_OFS);
   endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stage_q [STAGES];

   initial assert (STAGES >= 2) else $error("irqc_sync: STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_setclr_reg.sv
module irqc_setclr_reg #(
   parameter int unsigned W        = 32,
   parameter bit          RST_ONES = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= RST_VAL;
      else if (set_stb) q <= q | wdata;
      else if (clr_stb) q <= q & ~wdata;
   end

   a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((q & $past(wdata)) == $past(wdata)));
   a_r2_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb) |=> ((q & $past(wdata)) == '0));
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(q));
endmodule

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hit,
   input  logic [W-1:0] clr,
   output logic [W-1:0] lat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat <= '0;
      else        lat <= (lat & ~clr) | hit;
   end

   a_r7_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((lat & $past(hit)) == $past(hit)));
   a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr != '0 && hit == '0) |=> ((lat & $past(clr)) == '0));
endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NSRC        = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NSRC-1:0]   irq_in,
   output logic              req_hi,
   output logic              req_lo,
   output logic              wake_o
);
   initial assert (NSRC >= 1 && NSRC <= DATA_W)
      else $error("trig_irq_ctrl: NSRC must lie in 1..DATA_W");

   logic              wr_stb;
   logic [NSRC-1:0]   wsrc;
   logic [NSRC-1:0]   bank_q [NUM_BANKS];
   logic [DATA_W-1:0] test_q;

   assign wr_stb = bus_sel & bus_wr;
   assign wsrc   = bus_wdata[NSRC-1:0];

   // Set/clear register pairs, one per control word
   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
      logic set_k, clr_k;
      assign set_k = wr_stb && (bus_addr == bank_set_addr(k));
      assign clr_k = wr_stb && (bus_addr == bank_clr_addr(k));
      irqc_setclr_reg #(.W(NSRC), .RST_ONES(k == BK_SRC)) u_reg (
         .clk(clk), .rst_n(rst_n), .set_stb(set_k), .clr_stb(clr_k),
         .wdata(wsrc), .q(bank_q[k]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                test_q <= '0;
      else if (wr_stb && bus_addr == OFS_TEST)   test_q <= bus_wdata;
   end

   // Input synchronization and edge detection
   logic [NSRC-1:0] lvl_s, lvl_d;
   irqc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(irq_in), .dout(lvl_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= lvl_s;
   end

   // Per-source trigger decode
   logic [NSRC-1:0] rise_en, fall_en, hi_en, lo_en;
   always_comb begin
      for (int i = 0; i < NSRC; i++) begin
         rise_en[i] = 1'b0;
         fall_en[i] = 1'b0;
         hi_en[i]   = 1'b0;
         lo_en[i]   = 1'b0;
         case ({bank_q[BK_TRG2][i], bank_q[BK_TRG1][i], bank_q[BK_TRG0][i]})
            TRIG_RISE: rise_en[i] = 1'b1;
            TRIG_FALL: fall_en[i] = 1'b1;
            TRIG_BOTH: begin rise_en[i] = 1'b1; fall_en[i] = 1'b1; end
            TRIG_HIGH: hi_en[i] = 1'b1;
            TRIG_LOW:  lo_en[i] = 1'b1;
            default:   ;
         endcase
      end
   end

   logic [NSRC-1:0] rise_hit, fall_hit, rise_clr, fall_clr, rise_q, fall_q;
   assign rise_hit = lvl_s & ~lvl_d & rise_en;
   assign fall_hit = ~lvl_s & lvl_d & fall_en;
   assign rise_clr = (wr_stb && bus_addr == OFS_RISE) ? wsrc : '0;
   assign fall_clr = (wr_stb && bus_addr == OFS_FALL) ? wsrc : '0;

   irqc_edge_latch #(.W(NSRC)) u_rise (
      .clk(clk), .rst_n(rst_n), .hit(rise_hit), .clr(rise_clr), .lat(rise_q));
   irqc_edge_latch #(.W(NSRC)) u_fall (
      .clk(clk), .rst_n(rst_n), .hit(fall_hit), .clr(fall_clr), .lat(fall_q));

   // Activity, pending and routing
   logic [NSRC-1:0] active, pend, pend_hi, pend_lo;
   assign active  = (rise_q & rise_en) | (fall_q & fall_en)
                  | (lvl_s & hi_en) | (~lvl_s & lo_en);
   assign pend    = active & bank_q[BK_MASK];
   assign pend_hi = pend & bank_q[BK_STEER];
   assign pend_lo = pend & ~bank_q[BK_STEER];

   assign req_hi = |pend_hi;
   assign req_lo = |pend_lo;
   assign wake_o = |(active & bank_q[BK_WAKE]);

   // Read multiplexer
   logic [NSRC-1:0] rd_src;
   always_comb begin
      rd_src = '0;
      case (bus_addr)
         bank_set_addr(BK_TRG0):  rd_src = bank_q[BK_TRG0];
         bank_set_addr(BK_TRG1):  rd_src = bank_q[BK_TRG1];
         bank_set_addr(BK_TRG2):  rd_src = bank_q[BK_TRG2];
         bank_set_addr(BK_SRC):   rd_src = bank_q[BK_SRC];
         bank_set_addr(BK_STEER): rd_src = bank_q[BK_STEER];
         bank_set_addr(BK_WAKE):  rd_src = bank_q[BK_WAKE];
         bank_set_addr(BK_MASK):  rd_src = bank_q[BK_MASK];
         OFS_PEND_HI:             rd_src = pend_hi;
         OFS_PEND_LO:             rd_src = pend_lo;
         OFS_RISE:                rd_src = rise_q;
         OFS_FALL:                rd_src = fall_q;
         default:                 rd_src = '0;
      endcase
      bus_rdata = '0;
      if (bus_addr == OFS_TEST) bus_rdata = test_q;
      else                      bus_rdata[NSRC-1:0] = rd_src;
   end

   a_r8_req_hi_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      req_hi |-> ((bank_q[BK_MASK] & bank_q[BK_STEER]) != '0));
   a_r8_req_lo_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      req_lo |-> ((bank_q[BK_MASK] & ~bank_q[BK_STEER]) != '0));
   a_r6_no_capture_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_q & ~$past(rise_q) & ~$past(rise_en)) == '0));
endmodule

// File: tb/trig_irq_ctrl_tb_top.sv
module trig_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_drv = '0;
   logic        req_hi, req_lo, wake_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   trig_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_in(irq_drv), .req_hi(req_hi), .req_lo(req_lo), .wake_o(wake_o));

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_bank [7];
   logic [31:0] m_test, m_rise, m_fall, m_sync, m_prev;
   logic [31:0] hq [$];

   function automatic logic [2:0] m_code(input int i);
      return {m_bank[2][i], m_bank[1][i], m_bank[0][i]};
   endfunction

   function automatic logic [31:0] m_active();
      logic [31:0] a = '0;
      for (int i = 0; i < 32; i++) begin
         case (m_code(i))
            3'b001: a[i] = m_rise[i];
            3'b010: a[i] = m_fall[i];
            3'b011: a[i] = m_rise[i] | m_fall[i];
            3'b101: a[i] = m_sync[i];
            3'b110: a[i] = !m_sync[i];
            default: a[i] = 1'b0;
         endcase
      end
      return a;
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      logic [31:0] p = m_active() & m_bank[6];
      if (a == 8'h54) return p & m_bank[4];
      if (a == 8'h5C) return p & ~m_bank[4];
      if (a == 8'h78) return m_rise;
      if (a == 8'h7C) return m_fall;
      if (a == 8'h80) return m_test;
      for (int k = 0; k < 7; k++) if (a == 8'(8'h40 + 8 * k)) return m_bank[k];
      return '0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 7; k++) m_bank[k] = (k == 3) ? 32'hFFFF_FFFF : '0;
         m_test = '0; m_rise = '0; m_fall = '0; m_sync = '0; m_prev = '0;
         hq.delete();
      end else begin
         logic        w;
         logic [31:0] re, fe;
         re = '0; fe = '0;
         for (int i = 0; i < 32; i++) begin
            if (m_sync[i] && !m_prev[i] && (m_code(i) == 3'b001 || m_code(i) == 3'b011)) re[i] = 1'b1;
            if (!m_sync[i] && m_prev[i] && (m_code(i) == 3'b010 || m_code(i) == 3'b011)) fe[i] = 1'b1;
         end
         w = bus_sel && bus_wr;
         if (w && bus_addr == 8'h78) m_rise = m_rise & ~bus_wdata;
         if (w && bus_addr == 8'h7C) m_fall = m_fall & ~bus_wdata;
         m_rise = m_rise | re;
         m_fall = m_fall | fe;
         for (int k = 0; k < 7; k++) begin
            if (w && bus_addr == 8'(8'h40 + 8 * k)) m_bank[k] = m_bank[k] | bus_wdata;
            if (w && bus_addr == 8'(8'h44 + 8 * k)) m_bank[k] = m_bank[k] & ~bus_wdata;
         end
         if (w && bus_addr == 8'h80) m_test = bus_wdata;
         m_prev = m_sync;
         hq.push_back(irq_drv);
         if (hq.size() > 2) void'(hq.pop_front());
         m_sync = (hq.size() == 2) ? hq[0] : '0;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model, away from the clock edge
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         logic [31:0] p;
         p = m_active() & m_bank[6];
         check("R9 req_hi model", {31'b0, req_hi}, {31'b0, |(p & m_bank[4])});
         check("R9 req_lo model", {31'b0, req_lo}, {31'b0, |(p & ~m_bank[4])});
         check("R10 wake model", {31'b0, wake_o}, {31'b0, |(m_active() & m_bank[5])});
         if (bus_sel && !bus_wr) check("R2 read model", bus_rdata, m_read(bus_addr));
      end
   end

   // ---------------- bus tasks ----------------
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #3;
      check(tag, bus_rdata, exp);
   endtask

   task automatic pins(input string tag, input logic hi, input logic lo, input logic wk);
      @(negedge clk);
      #3;
      check(tag, {29'b0, req_hi, req_lo, wake_o}, {29'b0, hi, lo, wk});
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      pins("R1 outputs after reset", 1'b0, 1'b0, 1'b0);
      rd("R1 trig0", 8'h40, 32'h0);
      rd("R1 trig1", 8'h48, 32'h0);
      rd("R1 trig2", 8'h50, 32'h0);
      rd("R1 source", 8'h58, 32'hFFFF_FFFF);
      rd("R1 steer", 8'h60, 32'h0);
      rd("R1 wake", 8'h68, 32'h0);
      rd("R1 mask", 8'h70, 32'h0);
      rd("R1 rise", 8'h78, 32'h0);
      rd("R1 fall", 8'h7C, 32'h0);
      rd("R1 test", 8'h80, 32'h0);
      // R2 set/clear addressing
      wr(8'h70, 32'hF0F0_00FF);
      wr(8'h74, 32'h0000_000F);
      rd("R2 mask set/clear", 8'h70, 32'hF0F0_00F0);
      wr(8'h74, 32'hFFFF_FFFF);
      rd("R2 mask cleared", 8'h70, 32'h0);
      wr(8'h5C, 32'hFFFF_0000);
      rd("R2 source clear", 8'h58, 32'h0000_FFFF);
      // R11 test word
      wr(8'h80, 32'hA5A5_5A5A);
      rd("R11 test word", 8'h80, 32'hA5A5_5A5A);
      // R7 clear in the same cycle as a detected edge
      wr(8'h40, 32'h1);
      @(negedge clk); irq_drv = 32'h1;
      @(posedge clk); @(posedge clk);
      wr(8'h78, 32'h1);
      rd("R7 edge beats clear", 8'h78, 32'h1);
      irq_drv = 32'h0;
      idle(4);
      wr(8'h78, 32'hFFFF_FFFF);
      wr(8'h7C, 32'hFFFF_FFFF);
      rd("R7 rise cleared", 8'h78, 32'h0);
      // configure: 0 rise,1 fall,2 both,3 high,4 low,5 code100,6 code111
      wr(8'h40, 32'h0000_004D);
      wr(8'h48, 32'h0000_0056);
      wr(8'h50, 32'h0000_0078);
      wr(8'h70, 32'h0000_007F);
      wr(8'h60, 32'h0000_0009);
      irq_drv = 32'h10;
      idle(4);
      rd("R5 low level inactive hi", 8'h54, 32'h0);
      rd("R5 low level inactive lo", 8'h5C, 32'h0);
      irq_drv = 32'h17;
      idle(4);
      rd("R4 rising captures", 8'h78, 32'h05);
      rd("R4 no fall yet", 8'h7C, 32'h0);
      irq_drv = 32'h10;
      idle(4);
      rd("R4 falling captures", 8'h7C, 32'h06);
      rd("R9 pending hi word", 8'h54, 32'h01);
      rd("R9 pending lo word", 8'h5C, 32'h06);
      irq_drv = 32'h18;
      idle(4);
      rd("R5 high level pending", 8'h54, 32'h09);
      irq_drv = 32'h08;
      idle(4);
      rd("R5 low level pending", 8'h5C, 32'h16);
      // R6 disabled codes
      irq_drv = 32'h68;
      idle(4);
      irq_drv = 32'h08;
      idle(4);
      rd("R6 no rise capture", 8'h78, 32'h05);
      rd("R6 no fall capture", 8'h7C, 32'h06);
      rd("R6 not pending", 8'h5C, 32'h16);
      // R8 mask gating
      wr(8'h74, 32'h0000_007F);
      pins("R8 masked outputs", 1'b0, 1'b0, 1'b0);
      rd("R8 masked pending", 8'h54, 32'h0);
      wr(8'h70, 32'h0000_007F);
      pins("R9 both requests", 1'b1, 1'b1, 1'b0);
      // R10 wake
      wr(8'h68, 32'h08);
      pins("R10 wake from level", 1'b1, 1'b1, 1'b1);
      wr(8'h6C, 32'h08);
      wr(8'h68, 32'h20);
      pins("R10 wake off for disabled", 1'b1, 1'b1, 1'b0);
      // R7 plain clear
      wr(8'h78, 32'h01);
      rd("R7 partial clear", 8'h78, 32'h04);
      // R3 synchronizer latency: only src3 drives req_hi now
      @(negedge clk); bus_sel = 1'b0; irq_drv = 32'h00;
      @(negedge clk); #3;
      check("R3 still high after one edge", {31'b0, req_hi}, 32'h1);
      @(negedge clk); #3;
      check("R3 low after two edges", {31'b0, req_hi}, 32'h0);
      idle(3);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule